// File: doc/BRIEF.md
# Cascadable Serial Crosspoint Configuration Controller

This block sets the routing of a four-way crosspoint. Each of the four output lanes carries exactly one of the four input lanes, and every output chooses its input independently of the others. The routing is written through a one-wire serial stream clocked by a control clock. The stream fills a staging store. A separate load strobe then commits the whole staging store to the live routing in a single control-clock edge, so all outputs switch together.

Several identical devices can be chained. Each device passes the serial stream and a buffered copy of its control clock on to the next device. As it passes a frame on, it lowers the frame's address field by one. A device therefore acts on a frame only when the address it receives is zero, and a host reaches device k of the chain by sending address k. A mode input disconnects the control clock from the whole controller. While it is high, no register moves and the clock output stays low.

Top module: `xpt_serial_ctrl`

## Requirements
- R1: Output lane o, bits [o*LANE_W +: LANE_W] of `dout`, always equals input lane s, bits [s*LANE_W +: LANE_W] of `din`, where s is the live selection for output o. Each output selects independently of the others.
- R2: After reset, every live selection and every staged selection equals its own output index (straight-through), `sdo` is low and the receiver waits for a start bit.
- R3: `sdi` is sampled on rising `sclk` edges. While idle, a 1 on `sdi` is a start bit. It is followed by 8 frame bits, MSB first: address[3:0], output index[1:0], input index[1:0]. A new start bit may follow the last frame bit on the very next edge.
- R4: A complete frame whose received address is 0 writes its input index into the staged selection of its output index. A frame with any other address changes no staged selection. The live routing does not change until a load.
- R5: At a rising `sclk` edge with `load` high, all four staged selections are copied into the live selections in that edge.
- R6: Each edge with `load` high repeats the copy. Holding `load` for several edges ends in the same routing as a single-edge pulse.
- R7: At the edge that takes in a frame's last bit, `sdo` goes to a start bit (1). It then presents the received frame, MSB first, one bit per edge, with the address field reduced by 1 modulo 16 and the payload unchanged. Afterwards `sdo` returns low.
- R8: A received address of 0 is forwarded as 15. Devices further down the chain therefore do not act on it.
- R9: While `mode` is high, `cclk_out` is low and no edge reaches any register, so staging, routing and `sdo` hold their values. While `mode` is low, `cclk_out` follows `sclk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sclk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 1 | High: control clock cut off from the internals |
| sdi | input | 1 | Serial programming data |
| load | input | 1 | Commit strobe: staged selections become live |
| din | input | NPORT*LANE_W | Input lanes, lane k at bits [k*LANE_W +: LANE_W] |
| dout | output | NPORT*LANE_W | Output lanes, routed by the live selections |
| sdo | output | 1 | Forwarded serial stream with the address field reduced by 1 |
| cclk_out | output | 1 | Buffered control clock for the next device |

## Verification
A fault in the receiver's framing (bit count or start detection) shows up at `sdo` on the edge after the last bit. Either no start bit appears there, or the forwarded address is wrong, so devices further down the chain respond to the wrong frames. A wrong staged selection stays hidden until the next load edge. On that edge the fault appears on `dout` of only the output it belongs to. A live selection that moves without a load, or a register that moves while `mode` is high, changes `dout` or `sdo` on the same edge.

// File: rtl/xpt_pkg.sv
`timescale 1ns/1ps
package xpt_pkg;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_DATA = 1'b1
    } rx_state_e;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    localparam logic START_BIT = 1'b1;

endpackage

// File: rtl/xpt_rx_fsm.sv
`timescale 1ns/1ps
module xpt_rx_fsm
    import xpt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sdi,
    output logic              frame_done,
    output logic [ADDR_W-1:0] frame_addr,
    output logic [SEL_W-1:0]  frame_out,
    output logic [SEL_W-1:0]  frame_in
);
    localparam int FRAME_W = ADDR_W + 2*SEL_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    rx_state_e            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q, cnt_d;
    logic [FRAME_W-2:0]   sh_q, sh_d;
    logic                 last_bit;
    logic [FRAME_W-1:0]   frame_w;

    assign last_bit = (state_q == RX_DATA) && (cnt_q == CNT_W'(FRAME_W-1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else if (en) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        unique case (state_q)
            RX_IDLE: begin
                if (sdi == START_BIT) begin
                    state_d = RX_DATA;
                    cnt_d   = '0;
                end
            end
            RX_DATA: begin
                sh_d = {sh_q[FRAME_W-3:0], sdi};
                if (last_bit) begin
                    state_d = RX_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    // outputs
    always_comb begin
        frame_w    = {sh_q, sdi};
        frame_done = en && last_bit;
        frame_addr = frame_w[FRAME_W-1 -: ADDR_W];
        frame_out  = frame_w[2*SEL_W-1 -: SEL_W];
        frame_in   = frame_w[SEL_W-1:0];
    end

endmodule

// File: rtl/xpt_cascade_tx.sv
`timescale 1ns/1ps
module xpt_cascade_tx
    import xpt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              load_frame,
    input  logic [ADDR_W-1:0] frame_addr,
    input  logic [SEL_W-1:0]  frame_out,
    input  logic [SEL_W-1:0]  frame_in,
    output logic              sdo
);
    localparam int TX_W  = ADDR_W + 2*SEL_W + 1;
    localparam int CNT_W = $clog2(TX_W);

    tx_state_e          state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic [TX_W-1:0]    sh_q, sh_d;
    logic [ADDR_W-1:0]  next_addr;

    assign next_addr = ADDR_W'(frame_addr - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
        end else if (en) begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sh_q    <= sh_d;
        end
    end

    // next state: a new frame always takes over the shifter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        if (load_frame) begin
            state_d = TX_SEND;
            cnt_d   = CNT_W'(TX_W-1);
            sh_d    = {START_BIT, next_addr, frame_out, frame_in};
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    sh_d = '0;
                end
                TX_SEND: begin
                    sh_d = {sh_q[TX_W-2:0], 1'b0};
                    if (cnt_q == '0) begin
                        state_d = TX_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        sdo = sh_q[TX_W-1];
    end

endmodule

// File: rtl/xpt_route_store.sv
`timescale 1ns/1ps
module xpt_route_store #(
    parameter int NPORT  = 4,
    parameter int ADDR_W = 4,
    parameter int SEL_W  = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   frame_done,
    input  logic [ADDR_W-1:0]      frame_addr,
    input  logic [SEL_W-1:0]       frame_out,
    input  logic [SEL_W-1:0]       frame_in,
    input  logic                   load,
    output logic [NPORT*SEL_W-1:0] stage_flat,
    output logic [NPORT*SEL_W-1:0] cfg_flat
);
    logic hit;
    assign hit = frame_done && (frame_addr == '0);

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        logic [SEL_W-1:0] stage_q;
        logic [SEL_W-1:0] cfg_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= SEL_W'(o);
                cfg_q   <= SEL_W'(o);
            end else if (en) begin
                if (load) begin
                    cfg_q <= stage_q;
                end
                if (hit && (frame_out == SEL_W'(o))) begin
                    stage_q <= frame_in;
                end
            end
        end

        assign stage_flat[o*SEL_W +: SEL_W] = stage_q;
        assign cfg_flat[o*SEL_W +: SEL_W]   = cfg_q;
    end

endmodule

// File: rtl/xpt_lane_mux.sv
`timescale 1ns/1ps
module xpt_lane_mux #(
    parameter int NPORT  = 4,
    parameter int LANE_W = 4,
    parameter int SEL_W  = 2
) (
    input  logic [NPORT*LANE_W-1:0] din,
    input  logic [NPORT*SEL_W-1:0]  cfg_flat,
    output logic [NPORT*LANE_W-1:0] dout
);
    logic [LANE_W-1:0] lanes [NPORT];

    for (genvar k = 0; k < NPORT; k++) begin : g_in
        assign lanes[k] = din[k*LANE_W +: LANE_W];
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_sel
        always_comb begin
            dout[o*LANE_W +: LANE_W] = lanes[cfg_flat[o*SEL_W +: SEL_W]];
        end
    end

endmodule

// File: rtl/xpt_serial_ctrl.sv
`timescale 1ns/1ps
module xpt_serial_ctrl #(
    parameter int NPORT  = 4,
    parameter int LANE_W = 4,
    parameter int ADDR_W = 4
) (
    input  logic                    sclk,
    input  logic                    rst_n,
    input  logic                    mode,
    input  logic                    sdi,
    input  logic                    load,
    input  logic [NPORT*LANE_W-1:0] din,
    output logic [NPORT*LANE_W-1:0] dout,
    output logic                    sdo,
    output logic                    cclk_out
);
    localparam int SEL_W = $clog2(NPORT);

    logic                   en;
    logic                   frame_done;
    logic [ADDR_W-1:0]      frame_addr;
    logic [SEL_W-1:0]       frame_out;
    logic [SEL_W-1:0]       frame_in;
    logic [NPORT*SEL_W-1:0] stage_flat;
    logic [NPORT*SEL_W-1:0] cfg_flat;

    assign en       = ~mode;
    assign cclk_out = sclk & ~mode;

    xpt_rx_fsm #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_rx (
        .clk        (sclk),
        .rst_n      (rst_n),
        .en         (en),
        .sdi        (sdi),
        .frame_done (frame_done),
        .frame_addr (frame_addr),
        .frame_out  (frame_out),
        .frame_in   (frame_in)
    );

    xpt_cascade_tx #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_tx (
        .clk        (sclk),
        .rst_n      (rst_n),
        .en         (en),
        .load_frame (frame_done),
        .frame_addr (frame_addr),
        .frame_out  (frame_out),
        .frame_in   (frame_in),
        .sdo        (sdo)
    );

    xpt_route_store #(.NPORT(NPORT), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_store (
        .clk        (sclk),
        .rst_n      (rst_n),
        .en         (en),
        .frame_done (frame_done),
        .frame_addr (frame_addr),
        .frame_out  (frame_out),
        .frame_in   (frame_in),
        .load       (load),
        .stage_flat (stage_flat),
        .cfg_flat   (cfg_flat)
    );

    xpt_lane_mux #(.NPORT(NPORT), .LANE_W(LANE_W), .SEL_W(SEL_W)) u_mux (
        .din      (din),
        .cfg_flat (cfg_flat),
        .dout     (dout)
    );

endmodule

// File: rtl/xpt_serial_ctrl_chk.sv
`timescale 1ns/1ps
module xpt_serial_ctrl_chk #(
    parameter int NPORT = 4,
    parameter int SEL_W = 2
) (
    input logic                   sclk,
    input logic                   rst_n,
    input logic                   mode,
    input logic                   load,
    input logic                   frame_done,
    input logic                   sdo,
    input logic [NPORT*SEL_W-1:0] cfg_flat,
    input logic [NPORT*SEL_W-1:0] stage_flat
);
    // R5: a load edge makes the staged selections live
    a_r5_load_copies: assert property (@(posedge sclk) disable iff (!rst_n)
        (load && !mode) |=> (cfg_flat == $past(stage_flat)));

    // R4: without a load edge the live routing holds
    a_r4_hold_without_load: assert property (@(posedge sclk) disable iff (!rst_n)
        (!load || mode) |=> $stable(cfg_flat));

    // R9: mode high freezes staging and the cascade output
    a_r9_mode_freezes: assert property (@(posedge sclk) disable iff (!rst_n)
        mode |=> ($stable(stage_flat) && $stable(sdo)));

    // R7: a completed frame is followed by a start bit on sdo
    a_r7_start_bit: assert property (@(posedge sclk) disable iff (!rst_n)
        frame_done |=> sdo);

endmodule

bind xpt_serial_ctrl xpt_serial_ctrl_chk #(.NPORT(NPORT), .SEL_W(SEL_W)) u_chk (
    .sclk       (sclk),
    .rst_n      (rst_n),
    .mode       (mode),
    .load       (load),
    .frame_done (frame_done),
    .sdo        (sdo),
    .cfg_flat   (cfg_flat),
    .stage_flat (stage_flat)
);

// File: tb/xpt_serial_ctrl_tb.sv
`timescale 1ns/1ps
module xpt_serial_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        sdi = 1'b0;
    logic        load = 1'b0;
    logic [15:0] din_v = 16'hEB85;
    logic [15:0] dout_w [3];
    logic        sdo_w [3];
    logic        cck_w [3];

    int compared = 0;
    int mismatched = 0;
    int exp_stage [3][4];
    int exp_cfg   [3][4];
    bit frozen = 1'b0;

    typedef struct {
        int          dev;
        logic [15:0] val;
        string       tag;
    } sb_item_t;
    sb_item_t sbq [$];

    always #10 clk = ~clk;

    xpt_serial_ctrl u_dut (
        .sclk(clk), .rst_n(rst_n), .mode(mode), .sdi(sdi), .load(load),
        .din(din_v), .dout(dout_w[0]), .sdo(sdo_w[0]), .cclk_out(cck_w[0]));
    xpt_serial_ctrl u_dut_b (
        .sclk(cck_w[0]), .rst_n(rst_n), .mode(mode), .sdi(sdo_w[0]), .load(load),
        .din(din_v), .dout(dout_w[1]), .sdo(sdo_w[1]), .cclk_out(cck_w[1]));
    xpt_serial_ctrl u_dut_c (
        .sclk(cck_w[1]), .rst_n(rst_n), .mode(mode), .sdi(sdo_w[1]), .load(load),
        .din(din_v), .dout(dout_w[2]), .sdo(sdo_w[2]), .cclk_out(cck_w[2]));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] route_of(int d);
        logic [15:0] r;
        for (int o = 0; o < 4; o++) r[o*4 +: 4] = din_v[exp_cfg[d][o]*4 +: 4];
        return r;
    endfunction

    // driver side of the scoreboard
    task automatic expect_routes(string tag);
        for (int d = 0; d < 3; d++) begin
            sb_item_t it;
            it.dev = d; it.val = route_of(d); it.tag = tag;
            sbq.push_back(it);
        end
        wait (sbq.size() == 0);
    endtask

    // monitor side of the scoreboard
    initial begin
        forever begin
            wait (sbq.size() > 0);
            #1;
            begin
                sb_item_t it;
                it = sbq.pop_front();
                check($sformatf("%s dev%0d", it.tag, it.dev), 32'(dout_w[it.dev]), 32'(it.val));
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin @(negedge clk); sdi = 1'b0; end
    endtask

    // R3 frame: start bit, then addr[3:0], out[1:0], in[1:0], MSB first
    task automatic send_frame(int addr, int o, int i);
        logic [7:0] f;
        f = {4'(addr), 2'(o), 2'(i)};
        @(negedge clk); sdi = 1'b1;
        for (int b = 7; b >= 0; b--) begin @(negedge clk); sdi = f[b]; end
        if (!frozen)
            for (int d = 0; d < 3; d++)
                if (((addr - d) & 15) == 0) exp_stage[d][o] = i;
    endtask

    task automatic pulse_load(int n);
        @(negedge clk); load = 1'b1;
        repeat (n) @(negedge clk);
        load = 1'b0;
        if (!frozen)
            for (int d = 0; d < 3; d++)
                for (int o = 0; o < 4; o++) exp_cfg[d][o] = exp_stage[d][o];
    endtask

    task automatic capture_fwd(string req, logic [8:0] exp);
        logic [8:0] got;
        for (int k = 8; k >= 0; k--) begin
            @(negedge clk); sdi = 1'b0;
            got[k] = sdo_w[0];
        end
        check(req, 32'(got), 32'(exp));
    endtask

    initial begin
        #(200000 * 20);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int d = 0; d < 3; d++)
            for (int o = 0; o < 4; o++) begin exp_stage[d][o] = o; exp_cfg[d][o] = o; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        expect_routes("R2 reset straight-through");
        for (int d = 0; d < 3; d++) check($sformatf("R2 sdo idle dev%0d", d), 32'(sdo_w[d]), 0);

        // R4: only the addressed device stages, nothing live before load
        send_frame(1, 3, 0);
        idle(25);
        expect_routes("R4 no change before load");
        pulse_load(1);
        expect_routes("R5 single load dev1");

        // R3 back-to-back frames, R6 long load
        send_frame(0, 0, 2);
        send_frame(2, 1, 3);
        send_frame(2, 2, 0);
        idle(30);
        expect_routes("R4 staged only");
        pulse_load(3);
        expect_routes("R6 held load");
        pulse_load(2);
        expect_routes("R6 repeated load stable");

        // R7 forwarding with decrement, R3 bit order
        send_frame(5, 2, 1);
        capture_fwd("R7 forwarded frame", {1'b1, 4'd4, 2'd2, 2'd1});
        // R8 wrap of address 0
        send_frame(0, 3, 3);
        capture_fwd("R8 wrapped address", {1'b1, 4'd15, 2'd3, 2'd3});
        idle(30);
        pulse_load(1);
        expect_routes("R8 only dev0 changed");

        // R9 mode decouples the clock
        @(negedge clk); mode = 1'b1; frozen = 1'b1;
        @(posedge clk); #5;
        check("R9 cclk_out low in mode", 32'(cck_w[0]), 0);
        send_frame(1, 0, 1);
        idle(25);
        pulse_load(1);
        expect_routes("R9 frozen routing");
        @(negedge clk); mode = 1'b0; frozen = 1'b0;
        @(posedge clk); #5;
        check("R9 cclk_out follows sclk", 32'(cck_w[0]), 1);
        pulse_load(1);
        expect_routes("R9 frame ignored in mode");

        // R1 full reversal on dev2, and unmatched address 15
        send_frame(15, 0, 0);
        for (int o = 0; o < 4; o++) send_frame(2, o, 3 - o);
        idle(30);
        pulse_load(1);
        expect_routes("R1 reversal dev2");
        @(negedge clk); din_v = 16'h369C;
        expect_routes("R1 new input pattern");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule